// File: doc/BRIEF.md
# Bus-Mapped Parallel Port Expander

This block sits on an 8051-style external memory bus and adds two 8-bit input ports and two 8-bit output ports inside the external data address space. A processor reaches the ports with ordinary external-RAM read and write cycles. The block latches the top address bits when the address-latch strobe falls. It decodes those bits into one of eight 8 KB regions. Each port's select is then qualified by the matching read or write strobe. This two-step select keeps address-line glitches from firing a port.

The input ports hold no state. While a read cycle targets an input region, the block places the live pin value on the shared data byte and raises a drive-enable. At all other times the drive-enable stays low, which models a released bus. Each output port has a holding register. The register loads on the trailing (rising) edge of the write strobe and keeps its value until the next write to its region. All bus inputs are treated as synchronous to `clk`, and strobe edges are found by comparing each input with its value one cycle earlier.

Top module: `busio_expander`

## Requirements
- R1: While the latched region selects an input port (region 0 for input port 0, region 1 for input port 1), `rdN` is 0 and `wrN` is 1, `busDriveEn` is 1 and `busDataOut` equals that port's pins (`inPins[7:0]` for port 0, `inPins[15:8]` for port 1).
- R2: `busDriveEn` is 0 whenever `rdN` is 1, or the latched region is not an input region; `busDataOut` is then 00h.
- R3: The read path is unlatched: a change of the selected input pins during a read appears on `busDataOut` in the same cycle, without waiting for a clock edge.
- R4: A write cycle to region 2 loads output port 0 (`outPins[7:0]`), and one to region 3 loads output port 1 (`outPins[15:8]`). The value loaded is the last `busAdIn` sampled while `wrN` was 0. It appears after the first clock edge at which `wrN` is seen high following a low sample.
- R5: An output register keeps its value across idle cycles, read cycles, and write cycles to any other region.
- R6: Only address bits 15..13 (`busAddrTop`) are decoded. Every address in an 8 KB region aliases to the same port, so 0000h and 1FFFh both reach input port 0, and 7FFFh reaches output port 1.
- R7: The region is captured from `busAddrTop` at the clock edge where `ale` is first seen low after being high. Later changes of `busAddrTop` do not change which port answers until the next such fall.
- R8: If `rdN` and `wrN` are both 0, the bus is not driven, and the write still completes on the rise of `wrN`.
- R9: Synchronous reset `rst` clears both output registers to 00h, holds `busDriveEn` at 0, and leaves no region selected until an address is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| ale | input | 1 | Address-latch strobe, active high; falls after the address phase |
| busAddrTop | input | 3 | Address bits 15..13 from the high address byte |
| busAdIn | input | 8 | Multiplexed low address / data byte as seen from the bus |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| busDataOut | output | 8 | Data the block places on the bus during a read of an input port |
| busDriveEn | output | 1 | 1 while the block drives the bus; 0 models high impedance |
| inPins | input | 16 | Input port pins, port 1 in the upper byte |
| outPins | output | 16 | Output port registers, port 1 in the upper byte |

## Verification
The hardest conditions to reach are those where the bus breaks the normal cycle shape: address bits that move after the latch strobe has fallen, and read and write strobes that overlap. The stimulus latches one region, then drives a different region onto the address bits during the strobe. The check is that the latched region still wins, for reads and for writes. A separate pass asserts both strobes together and releases the write while the read is still low. It also drives garbage onto the data byte in the same cycle that the write strobe rises, so the bench can see that the register takes the value held during the strobe.

// File: rtl/busio_pkg.sv
package busio_pkg;
  localparam int unsigned IN_PORTS  = 2;
  localparam int unsigned OUT_PORTS = 2;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned SEL_W     = 3;
  localparam int unsigned REGIONS   = 1 << SEL_W;

  typedef struct packed {
    logic [IN_PORTS-1:0]  rdSel;
    logic [OUT_PORTS-1:0] wrLoad;
    logic                 capture;
  } strobe_t;
endpackage

// File: rtl/busio_ctrl.sv
module busio_ctrl
  import busio_pkg::*;
#(
  parameter int unsigned IN_BASE  = 0,
  parameter int unsigned OUT_BASE = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ale,
  input  logic [SEL_W-1:0] addrTop,
  input  logic             rdN,
  input  logic             wrN,
  output strobe_t          strb
);
  localparam logic [SEL_W-1:0] IDLE_REGION = {SEL_W{1'b1}};

  logic             aleQ;
  logic             wrQ;
  logic [SEL_W-1:0] regionQ;
  logic             wrRise;
  logic             readPhase;

  // Address phase capture and strobe history
  always_ff @(posedge clk) begin
    if (rst) begin
      aleQ    <= 1'b0;
      wrQ     <= 1'b1;
      regionQ <= IDLE_REGION;
    end else begin
      aleQ <= ale;
      wrQ  <= wrN;
      if (aleQ && !ale) regionQ <= addrTop;
    end
  end

  assign wrRise    = !wrQ && wrN;
  assign readPhase = !rst && !rdN && wrN;

  // Region decode qualified by the read strobe
  for (genvar i = 0; i < IN_PORTS; i++) begin : g_rd
    localparam logic [SEL_W-1:0] MY_REGION = SEL_W'(IN_BASE + i);
    assign strb.rdSel[i] = readPhase && (regionQ == MY_REGION);
  end

  // Region decode qualified by the trailing write edge
  for (genvar j = 0; j < OUT_PORTS; j++) begin : g_wr
    localparam logic [SEL_W-1:0] MY_REGION = SEL_W'(OUT_BASE + j);
    assign strb.wrLoad[j] = !rst && wrRise && (regionQ == MY_REGION);
  end

  assign strb.capture = !rst && !wrN;
endmodule

// File: rtl/busio_datapath.sv
module busio_datapath
  import busio_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst,
  input  strobe_t                       strb,
  input  logic [DATA_W-1:0]             busAdIn,
  input  logic [IN_PORTS*DATA_W-1:0]    inPins,
  output logic [DATA_W-1:0]             busDataOut,
  output logic                          busDriveEn,
  output logic [OUT_PORTS*DATA_W-1:0]   outPins
);
  logic [DATA_W-1:0] dataHold;

  // Last bus byte seen while the write strobe is low
  always_ff @(posedge clk) begin
    if (rst)               dataHold <= '0;
    else if (strb.capture) dataHold <= busAdIn;
  end

  for (genvar j = 0; j < OUT_PORTS; j++) begin : g_out
    logic [DATA_W-1:0] holdReg;
    always_ff @(posedge clk) begin
      if (rst)                 holdReg <= '0;
      else if (strb.wrLoad[j]) holdReg <= dataHold;
    end
    assign outPins[j*DATA_W +: DATA_W] = holdReg;
  end

  // Unlatched read path: one-hot select, OR mux
  always_comb begin
    busDataOut = '0;
    for (int i = 0; i < IN_PORTS; i++) begin
      if (strb.rdSel[i]) busDataOut |= inPins[i*DATA_W +: DATA_W];
    end
  end

  assign busDriveEn = |strb.rdSel;
endmodule

// File: rtl/busio_expander.sv
module busio_expander
  import busio_pkg::*;
#(
  parameter int unsigned IN_BASE  = 0,
  parameter int unsigned OUT_BASE = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        ale,
  input  logic [SEL_W-1:0]            busAddrTop,
  input  logic [DATA_W-1:0]           busAdIn,
  input  logic                        rdN,
  input  logic                        wrN,
  output logic [DATA_W-1:0]           busDataOut,
  output logic                        busDriveEn,
  input  logic [IN_PORTS*DATA_W-1:0]  inPins,
  output logic [OUT_PORTS*DATA_W-1:0] outPins
);
  strobe_t strb;

  busio_ctrl #(
    .IN_BASE (IN_BASE),
    .OUT_BASE(OUT_BASE)
  ) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .ale    (ale),
    .addrTop(busAddrTop),
    .rdN    (rdN),
    .wrN    (wrN),
    .strb   (strb)
  );

  busio_datapath u_dp (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .busAdIn   (busAdIn),
    .inPins    (inPins),
    .busDataOut(busDataOut),
    .busDriveEn(busDriveEn),
    .outPins   (outPins)
  );
endmodule

// File: rtl/busio_expander_chk.sv
module busio_expander_chk
  import busio_pkg::*;
(
  input logic                        clk,
  input logic                        rst,
  input logic                        rdN,
  input logic                        wrN,
  input logic [DATA_W-1:0]           busDataOut,
  input logic                        busDriveEn,
  input logic [IN_PORTS*DATA_W-1:0]  inPins,
  input logic [OUT_PORTS*DATA_W-1:0] outPins
);
  logic pinMatch;
  always_comb begin
    pinMatch = 1'b0;
    for (int i = 0; i < IN_PORTS; i++) begin
      if (busDataOut == inPins[i*DATA_W +: DATA_W]) pinMatch = 1'b1;
    end
  end

  p_drive_needs_read_r2: assert property (@(posedge clk) disable iff (rst)
    busDriveEn |-> !rdN);

  p_drive_shows_pins_r1: assert property (@(posedge clk) disable iff (rst)
    busDriveEn |-> pinMatch);

  p_idle_bus_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !busDriveEn |-> (busDataOut == '0));

  p_no_drive_in_write_r8: assert property (@(posedge clk) disable iff (rst)
    !wrN |-> !busDriveEn);

  p_hold_between_writes_r5: assert property (@(posedge clk) disable iff (rst)
    !(!$past(wrN) && wrN) |=> $stable(outPins));

  p_reset_clears_r9: assert property (@(posedge clk)
    rst |=> (outPins == '0) && !busDriveEn);
endmodule

bind busio_expander busio_expander_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .rdN       (rdN),
  .wrN       (wrN),
  .busDataOut(busDataOut),
  .busDriveEn(busDriveEn),
  .inPins    (inPins),
  .outPins   (outPins)
);

// File: tb/busio_expander_tb.sv
module busio_expander_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ale = 1'b0;
  logic [2:0]  busAddrTop = 3'b111;
  logic [7:0]  busAdIn = 8'h00;
  logic        rdN = 1'b1;
  logic        wrN = 1'b1;
  logic [7:0]  busDataOut;
  logic        busDriveEn;
  logic [15:0] inPins = 16'h0000;
  logic [15:0] outPins;

  int nCmp = 0;
  int nBad = 0;

  always #2 clk = ~clk;

  busio_expander u_dut (
    .clk(clk), .rst(rst), .ale(ale), .busAddrTop(busAddrTop),
    .busAdIn(busAdIn), .rdN(rdN), .wrN(wrN),
    .busDataOut(busDataOut), .busDriveEn(busDriveEn),
    .inPins(inPins), .outPins(outPins)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Address phase: addrTop = bits 15..13, lowByte = bits 7..0 on the muxed byte
  task automatic latchAddr(input logic [15:0] addr);
    @(negedge clk);
    ale = 1'b1; busAddrTop = addr[15:13]; busAdIn = addr[7:0];
    @(negedge clk);
    ale = 1'b0;
    @(negedge clk);
  endtask

  task automatic writeCycle(input logic [7:0] data);
    busAdIn = data; wrN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    wrN = 1'b1; busAdIn = ~data;  // garbage on the rising edge of wrN
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R9 outputs in reset", {16'h0, outPins}, 32'h0);
    chk("R9 no drive in reset", {31'h0, busDriveEn}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    rdN = 1'b0; #1;
    chk("R9 no region after reset", {31'h0, busDriveEn}, 32'h0);
    rdN = 1'b1;
  endtask

  task automatic t_read_basic;
    inPins = 16'hC35A;
    latchAddr(16'h0000);
    rdN = 1'b0; #1;
    chk("R1 drive port0", {31'h0, busDriveEn}, 32'h1);
    chk("R1 data port0", {24'h0, busDataOut}, 32'h5A);
    rdN = 1'b1;
    latchAddr(16'h2000);
    rdN = 1'b0; #1;
    chk("R1 data port1", {24'h0, busDataOut}, 32'hC3);
    rdN = 1'b1;
  endtask

  task automatic t_read_live;
    latchAddr(16'h0010);
    rdN = 1'b0; #1;
    inPins[7:0] = 8'h91; #1;
    chk("R3 live pin change", {24'h0, busDataOut}, 32'h91);
    @(negedge clk);
    inPins[7:0] = 8'h17; #1;
    chk("R3 second change", {24'h0, busDataOut}, 32'h17);
    rdN = 1'b1; #1;
    chk("R2 released after read", {23'h0, busDriveEn, busDataOut}, 32'h0);
  endtask

  task automatic t_no_drive;
    latchAddr(16'h4000);
    rdN = 1'b0; #1;
    chk("R2 output region no drive", {23'h0, busDriveEn, busDataOut}, 32'h0);
    rdN = 1'b1;
    latchAddr(16'hA123);
    rdN = 1'b0; #1;
    chk("R2 unused region no drive", {31'h0, busDriveEn}, 32'h0);
    rdN = 1'b1;
  endtask

  task automatic t_write;
    latchAddr(16'h4000);
    writeCycle(8'h3C);
    chk("R4 write port0", {16'h0, outPins}, 32'h003C);
    latchAddr(16'h6000);
    writeCycle(8'hA5);
    chk("R4 write port1", {16'h0, outPins}, 32'hA53C);
  endtask

  task automatic t_hold;
    latchAddr(16'h0000);
    writeCycle(8'hFF);
    chk("R5 write to input region", {16'h0, outPins}, 32'hA53C);
    latchAddr(16'hE000);
    writeCycle(8'h11);
    chk("R5 write to unused region", {16'h0, outPins}, 32'hA53C);
    latchAddr(16'h4000);
    rdN = 1'b0;
    repeat (3) @(negedge clk);
    rdN = 1'b1;
    repeat (5) @(negedge clk);
    chk("R5 read and idle keep value", {16'h0, outPins}, 32'hA53C);
  endtask

  task automatic t_alias;
    inPins = 16'h8E4D;
    latchAddr(16'h1FFF);
    rdN = 1'b0; #1;
    chk("R6 1FFFh reads port0", {24'h0, busDataOut}, 32'h4D);
    rdN = 1'b1;
    latchAddr(16'h7FFF);
    writeCycle(8'h6B);
    chk("R6 7FFFh writes port1", {16'h0, outPins}, 32'h6B3C);
  endtask

  task automatic t_glitch;
    latchAddr(16'h4000);
    busAddrTop = 3'b000;
    rdN = 1'b0; #1;
    chk("R7 read after addr move", {31'h0, busDriveEn}, 32'h0);
    busAddrTop = 3'b011;
    @(negedge clk);
    rdN = 1'b1;
    busAddrTop = 3'b001;
    writeCycle(8'hD2);
    chk("R7 write to latched region", {16'h0, outPins}, 32'h6BD2);
  endtask

  task automatic t_both;
    latchAddr(16'h0000);
    rdN = 1'b0; wrN = 1'b0; #1;
    chk("R8 both strobes no drive", {31'h0, busDriveEn}, 32'h0);
    rdN = 1'b1; wrN = 1'b1;
    latchAddr(16'h6000);
    rdN = 1'b0;
    busAdIn = 8'h77; wrN = 1'b0;
    @(negedge clk); #1;
    chk("R8 no drive during overlap", {31'h0, busDriveEn}, 32'h0);
    @(negedge clk);
    wrN = 1'b1; busAdIn = 8'h00;
    @(negedge clk);
    @(negedge clk);
    rdN = 1'b1;
    chk("R8 write completes", {16'h0, outPins}, 32'h77D2);
  endtask

  task automatic t_reset_again;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R9 reset clears registers", {16'h0, outPins}, 32'h0);
    rst = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin : main
    t_reset();
    t_read_basic();
    t_read_live();
    t_no_drive();
    t_write();
    t_hold();
    t_alias();
    t_glitch();
    t_both();
    t_reset_again();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule